// File: doc/BRIEF.md
# I2C GPIO Expander Port Logic

This block is the register and pin logic of an eight-bit general-purpose I/O expander that hangs off an I2C target. A byte-level front end hands it an address byte with a read/write flag, then written bytes and read requests. The block compares the 7-bit address with a fixed upper nibble plus three strap pins, so eight such expanders can share one bus.

The first byte written after a match is a command byte. Its low two bits pick one of four registers: pin sample, drive level, read-inversion mask and direction. Later bytes in the same transfer write or read that register. Every pin is an input or an output on its own. Inputs pass through a two-flop synchronizer. An active-low interrupt line flags any input-mode pin whose level no longer matches the last sample taken. Reading the sample register takes a fresh sample, which clears that condition.

Top module: `gpio_xpdr`

## Requirements
- R1: After reset the drive-level register is 0xFF, the inversion mask is 0x00 and the direction register is 0xFF. All pins are then inputs (pin_oe_o = 0x00, pin_o = 0xFF) and int_no is high.
- R2: A transfer is accepted only when addr_i equals {BASE_HI, addr_sel_i}, with BASE_HI = 4'b0100 by default. ack_o goes high one cycle after a matching xfer_start_i and low after a mismatching one. Bytes that follow a mismatching address change no register.
- R3: The first byte written after a matching write address is a command byte. Bits [1:0] select the register: 0 = pin sample, 1 = drive level, 2 = inversion mask, 3 = direction. Bits [7:2] are ignored.
- R4: Each later written byte is stored into the selected register. A write aimed at the pin sample register has no effect.
- R5: Reading the drive-level, inversion-mask or direction register returns its stored value. rd_valid_o pulses one cycle after rd_req_i.
- R6: Reading the pin sample register returns the synchronized pin levels XOR the inversion mask, bit by bit.
- R7: pin_oe_o[i] is the inverse of direction bit i (0 = output), and pin_o carries the drive-level register.
- R8: int_no is low while any pin whose direction bit is 1 differs from the stored pin sample. Differences on output-mode pins never pull it low.
- R9: A read of the pin sample register stores the synchronized pin levels, so int_no returns high until an input pin changes again.
- R10: A pin change reaches int_no after exactly two clock edges, through a two-flop synchronizer.
- R11: The register pointer does not auto-increment: repeated reads in one transfer return the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_sel_i | input | 3 | Strap pins forming the low address bits |
| xfer_start_i | input | 1 | Address byte received strobe |
| addr_i | input | 7 | Received target address |
| rnw_i | input | 1 | 1 = read transfer, 0 = write transfer |
| wr_valid_i | input | 1 | Written data byte strobe |
| wr_data_i | input | 8 | Written data byte |
| rd_req_i | input | 1 | Request for the next read byte |
| rd_valid_o | output | 1 | Read byte valid, one cycle after the request |
| rd_data_o | output | 8 | Read byte |
| ack_o | output | 1 | Block is addressed in the current transfer |
| pin_i | input | 8 | Pin levels seen at the pads |
| pin_o | output | 8 | Pin drive levels |
| pin_oe_o | output | 8 | Pin output enables |
| int_no | output | 1 | Change interrupt, active low (open-drain level) |

## Verification
Pins are looped back through the bench: output-enabled bits take pin_o, and the rest take an external pattern. The bench reads the sample register with all pins as inputs and a non-zero inversion mask, so an inversion fault and a missing-capture fault give different values. It then splits the port into output and input nibbles and toggles only output-mode pins, which separates a correctly masked interrupt from an unmasked one. A single-bit change checked one edge and then two edges later tells a two-stage synchronizer from a one-stage or three-stage one. A mismatched address, a command byte with high bits set and a write to the sample register catch decode and write-enable faults.

// File: rtl/gpio_xpdr_pkg.sv
package gpio_xpdr_pkg;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);

  typedef enum logic [SEL_W-1:0] {
    REG_IN  = 2'd0,
    REG_OUT = 2'd1,
    REG_POL = 2'd2,
    REG_CFG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_xpdr_sync.sv
module gpio_xpdr_sync #(
  parameter int unsigned WIDTH     = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg1_q, stg2_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg1_q[i] <= RST_VAL[i];
        stg2_q[i] <= RST_VAL[i];
      end else begin
        stg1_q[i] <= d_i[i];
        stg2_q[i] <= stg1_q[i];
      end
    end
  end

  assign q_o = stg2_q;

  // warm-up count so the check never looks behind reset
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  // R10
  sync_two_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_xpdr_ptr.sv
module gpio_xpdr_ptr
  import gpio_xpdr_pkg::*;
#(
  parameter logic [3:0] BASE_HI = 4'b0100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_sel_i,
  input  logic             xfer_start_i,
  input  logic [6:0]       addr_i,
  input  logic             rnw_i,
  input  logic             wr_valid_i,
  input  logic [SEL_W-1:0] cmd_i,
  input  logic             rd_req_i,
  output logic             sel_o,
  output logic             we_o,
  output logic             re_o,
  output reg_sel_e         ptr_o
);
  logic     sel_q, rnw_q, first_q;
  reg_sel_e ptr_q;
  logic     match;
  logic     wr_ok;

  assign match = (addr_i == {BASE_HI, addr_sel_i});
  assign wr_ok = wr_valid_i && sel_q && !rnw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      rnw_q   <= 1'b0;
      first_q <= 1'b0;
      ptr_q   <= REG_IN;
    end else if (xfer_start_i) begin
      sel_q   <= match;
      rnw_q   <= rnw_i;
      first_q <= !rnw_i;
    end else if (wr_ok && first_q) begin
      ptr_q   <= reg_sel_e'(cmd_i);
      first_q <= 1'b0;
    end
  end

  assign sel_o = sel_q;
  assign we_o  = wr_ok && !first_q;
  assign re_o  = rd_req_i && sel_q && rnw_q;
  assign ptr_o = ptr_q;

  // R2
  addr_mismatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_i && (addr_i != {BASE_HI, addr_sel_i})) |=> !sel_o);

  // R3
  cmd_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_start_i && wr_ok && first_q) |=> (ptr_o == $past(cmd_i)));
endmodule

// File: rtl/gpio_xpdr_regs.sv
module gpio_xpdr_regs
  import gpio_xpdr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  reg_sel_e         ptr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic             rvalid_o,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] cfg_o,
  output logic             int_no
);
  logic [WIDTH-1:0] in_q, out_q, pol_q, cfg_q;
  logic [WIDTH-1:0] rd_mux;

  always_comb begin
    unique case (ptr_i)
      REG_IN:  rd_mux = pin_sync_i ^ pol_q;
      REG_OUT: rd_mux = out_q;
      REG_POL: rd_mux = pol_q;
      default: rd_mux = cfg_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '1;
      out_q <= '1;
      pol_q <= '0;
      cfg_q <= '1;
    end else begin
      if (re_i && ptr_i == REG_IN) in_q <= pin_sync_i;
      if (we_i) begin
        unique case (ptr_i)
          REG_OUT: out_q <= wdata_i;
          REG_POL: pol_q <= wdata_i;
          REG_CFG: cfg_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= re_i;
      if (re_i) rdata_o <= rd_mux;
    end
  end

  assign out_o  = out_q;
  assign cfg_o  = cfg_q;
  assign int_no = ~|((pin_sync_i ^ in_q) & cfg_q);

  // R9
  capture_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && ptr_i == REG_IN) |=> (in_q == $past(pin_sync_i)));

  // R4
  in_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !re_i && ptr_i == REG_IN) |=> $stable(in_q));

  // R5
  read_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> rvalid_o);
endmodule

// File: rtl/gpio_xpdr.sv
module gpio_xpdr
  import gpio_xpdr_pkg::*;
#(
  parameter int unsigned WIDTH   = 8,
  parameter logic [3:0]  BASE_HI = 4'b0100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_sel_i,
  input  logic             xfer_start_i,
  input  logic [6:0]       addr_i,
  input  logic             rnw_i,
  input  logic             wr_valid_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_req_i,
  output logic             rd_valid_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             ack_o,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic             int_no
);
  logic             we, re;
  reg_sel_e         ptr;
  logic [WIDTH-1:0] pin_sync, cfg;

  gpio_xpdr_sync #(.WIDTH(WIDTH), .RST_VAL('1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_xpdr_ptr #(.BASE_HI(BASE_HI)) u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_sel_i   (addr_sel_i),
    .xfer_start_i (xfer_start_i),
    .addr_i       (addr_i),
    .rnw_i        (rnw_i),
    .wr_valid_i   (wr_valid_i),
    .cmd_i        (wr_data_i[SEL_W-1:0]),
    .rd_req_i     (rd_req_i),
    .sel_o        (ack_o),
    .we_o         (we),
    .re_o         (re),
    .ptr_o        (ptr)
  );

  gpio_xpdr_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we),
    .re_i       (re),
    .ptr_i      (ptr),
    .wdata_i    (wr_data_i),
    .pin_sync_i (pin_sync),
    .rvalid_o   (rd_valid_o),
    .rdata_o    (rd_data_o),
    .out_o      (pin_o),
    .cfg_o      (cfg),
    .int_no     (int_no)
  );

  assign pin_oe_o = ~cfg;

  // R7
  oe_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && ptr == REG_CFG) |=> (pin_oe_o == ~$past(wr_data_i)));
endmodule

// File: tb/gpio_xpdr_bench.sv
module gpio_xpdr_bench;
  localparam logic [2:0] SEL   = 3'b101;
  localparam logic [6:0] MY_AD = {4'b0100, SEL};
  localparam logic [6:0] NO_AD = {4'b0100, 3'b100};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_start = 1'b0, rnw = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wr_data = '0, ext = 8'hFF;
  logic       rd_valid, ack, int_n;
  logic [7:0] rd_data, pin_in, pin_out, pin_oe;

  int vectors = 0, miscompares = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_xpdr u_gpio_xpdr (
    .clk_i(clk), .rst_ni(rst_n), .addr_sel_i(SEL), .xfer_start_i(xfer_start),
    .addr_i(addr), .rnw_i(rnw), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .ack_o(ack),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .int_no(int_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start(input logic [6:0] a, input logic r);
    @(negedge clk); xfer_start = 1'b1; addr = a; rnw = r;
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  // driver: issue a read and push the expected byte
  task automatic rbyte(input logic [7:0] exp, input string req);
    @(negedge clk); rd_req = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] r, input logic [7:0] exp, input string req);
    start(MY_AD, 1'b0); wbyte({6'd0, r});
    start(MY_AD, 1'b1); rbyte(exp, req);
  endtask

  task automatic write_reg(input logic [1:0] r, input logic [7:0] d);
    start(MY_AD, 1'b0); wbyte({6'd0, r}); wbyte(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pop and compare as read bytes appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R5 unexpected rd_valid", 8'h01, 8'h00);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R1 reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_o", pin_out, 8'hFF);
    check("R1 int_no", {7'd0, int_n}, 8'h01);
    read_reg(2'd1, 8'hFF, "R1 R5 out reg");
    read_reg(2'd2, 8'h00, "R1 R5 pol reg");
    read_reg(2'd3, 8'hFF, "R1 R5 cfg reg");
    read_reg(2'd0, 8'hFF, "R6 input at reset");

    // R2 wrong address ignored
    start(NO_AD, 1'b0);
    check("R2 ack low on mismatch", {7'd0, ack}, 8'h00);
    wbyte(8'h01); wbyte(8'h00);
    start(MY_AD, 1'b0);
    check("R2 ack high on match", {7'd0, ack}, 8'h01);
    read_reg(2'd1, 8'hFF, "R2 out unchanged");

    // R3 high command bits ignored -> pol register
    start(MY_AD, 1'b0); wbyte(8'hFE); wbyte(8'h0F);
    read_reg(2'd2, 8'h0F, "R3 R4 pol written");

    // R8 input change raises interrupt
    ext = 8'hA5; idle(4);
    check("R8 int on input change", {7'd0, int_n}, 8'h00);
    read_reg(2'd0, 8'hAA, "R6 input xor pol");
    idle(1);
    check("R9 int cleared by read", {7'd0, int_n}, 8'h01);

    // R4 write to input register ignored
    write_reg(2'd0, 8'h00);
    idle(2);
    check("R4 int unchanged", {7'd0, int_n}, 8'h01);
    read_reg(2'd0, 8'hAA, "R4 input unchanged");

    // R7 direction and drive
    write_reg(2'd3, 8'hF0);
    write_reg(2'd1, 8'h3C);
    idle(1);
    check("R7 pin_oe", pin_oe, 8'h0F);
    check("R7 pin_o", pin_out, 8'h3C);
    idle(3);
    check("R8 output pins masked", {7'd0, int_n}, 8'h01);
    write_reg(2'd1, 8'h33);
    idle(4);
    check("R8 output toggle masked", {7'd0, int_n}, 8'h01);

    // R10 two-edge latency
    @(negedge clk); ext = 8'h25;
    @(negedge clk);
    check("R10 no int after one edge", {7'd0, int_n}, 8'h01);
    @(negedge clk);
    check("R10 int after two edges", {7'd0, int_n}, 8'h00);

    // R11 no auto-increment
    start(MY_AD, 1'b0); wbyte(8'h00);
    start(MY_AD, 1'b1);
    rbyte(8'h2C, "R11 first read");
    rbyte(8'h2C, "R11 second read");
    idle(1);
    check("R9 int cleared", {7'd0, int_n}, 8'h01);

    idle(4);
    check("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule